// File: doc/BRIEF.md
# Downlink command frame assembler

This block turns one command for a low-frequency transponder into a serial bit frame and hands that frame out one bit at a time to a downlink modulator. A single start pulse captures an 8-bit command flags word, a 32-bit password, 32-bit write data and a 3-bit block address. The frame is built in one step and loaded into a shift register. It is then emitted, first bit first, over a valid/ready stream that marks the final bit. Within every multi-bit field the most significant bit goes out first.

The 2-bit downlink mode in the flags decides whether reference zeros come before the opcode. It also decides whether padding zeros come before the password. The other flags choose among a reset command, a test-mode opcode, a read that carries no data field, and a register read that carries neither lock bit nor block address. The modulator reads the captured mode from a plain output and uses it to pick its pulse timing. Pulse widths, the long reference pulse itself and field control are all left to the modulator.

Back-pressure rules: `bit_valid` stays high for the whole frame. While `bit_ready` is low, `bit_data` and `bit_last` hold their values. A bit is consumed on each rising edge where `bit_valid` and `bit_ready` are both high. A frame longer than the internal buffer is never started.

Top module: `dl_frame_asm`

## Requirements
- R1: After reset `busy`, `bit_valid`, `bit_last`, `reject` and `frame_len` are all 0.
- R2: In a normal write (flags bit7 reset = 0, bit6 read = 0, bit5 register-read = 0, bit2 test = 0, bit0 password = 0), the frame is sent in this order: opcode bit 1, the page bit (flags bit1), a lock bit 0, the 32 data bits MSB first, and the 3 address bits MSB first.
- R3: The downlink mode in flags bits 4:3 controls the reference zeros. Mode 2 (leading zero) puts one 0 bit at the head of the frame. Mode 3 (1-of-4) puts two 0 bits there. Modes 0 (fixed) and 1 (long reference) add none.
- R4: When flags bit7 (reset) is set, the frame is the reference zeros followed by the opcode 0,0 and nothing more. Its length is 2, 2, 3 or 4 for modes 0 to 3.
- R5: When flags bit2 (test) is set, the opcode is 0 then 1, whatever the page bit holds.
- R6: When flags bit0 (password) is set, the 32 password bits follow the opcode MSB first. In modes 2 and 3 two 0 bits come between the opcode and the password. A mode 3 write with a password is 74 bits long.
- R7: Flags bit6 (read) removes the data field. Flags bit5 (register-read) removes both the lock bit and the address.
- R8: One cycle after an accepted or rejected start, `frame_len` holds the total bit count of that frame. It stays unchanged while the frame is being sent.
- R9: While `bit_valid` is high and `bit_ready` is low, `bit_data` and `bit_last` stay stable. Each handshake consumes exactly one bit. `bit_last` is high only with the final bit.
- R10: `busy` rises the cycle after an accepted start and falls right after the handshake on the final bit. A start pulse, and any change on the command inputs, while `busy` is high have no effect on the frame.
- R11: A frame longer than `BUF_BITS` produces a one-cycle `reject` pulse. In that case `busy` stays low and no bit is emitted.
- R12: `dl_mode` shows the downlink mode captured at the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the command inputs and begin a frame (ignored while busy) |
| cmd_flags | input | 8 | Command flags: bit0 password, bit1 page, bit2 test, bits4:3 mode, bit5 register-read, bit6 read, bit7 reset |
| password | input | 32 | Password field |
| wr_data | input | 32 | Write data field |
| blk_addr | input | 3 | Block address field |
| busy | output | 1 | A frame is in flight |
| frame_len | output | LEN_W (7) | Bit count of the last started or rejected frame |
| dl_mode | output | 2 | Downlink mode of the frame in flight |
| reject | output | 1 | One-cycle pulse when a frame does not fit the buffer |
| bit_valid | output | 1 | Stream: a frame bit is offered |
| bit_ready | input | 1 | Stream: the modulator takes the offered bit |
| bit_data | output | 1 | Stream: the offered bit |
| bit_last | output | 1 | Stream: the offered bit ends the frame |

## Verification
The overflow rejection is hard to reach: with the default 80-bit buffer even the longest frame (74 bits) fits, so the path can never be taken at the default size. The bench therefore adds a second instance with a 40-bit buffer. It sends that instance a mode 3 password write, which must be rejected, and a short reset command, which must still go through. The ignore-while-busy rule is reached by pulsing start with different command inputs partway through a stalled frame. The bench then confirms that the full bit stream and the reported length still match the original command.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED   = 2'd0,
    MODE_LONGREF = 2'd1,
    MODE_LEADZ   = 2'd2,
    MODE_ONE4    = 2'd3
  } dl_mode_e;

  typedef struct packed {
    logic     reset;
    logic     rd_only;
    logic     reg_rd;
    dl_mode_e mode;
    logic     test;
    logic     page;
    logic     pwd_en;
  } cmd_flags_t;

  function automatic int ref_zeros(dl_mode_e m);
    case (m)
      MODE_LEADZ: return 1;
      MODE_ONE4:  return 2;
      default:    return 0;
    endcase
  endfunction

  function automatic logic pads_password(dl_mode_e m);
    return (m == MODE_LEADZ) || (m == MODE_ONE4);
  endfunction

endpackage

// File: rtl/dlf_builder.sv
module dlf_builder
  import dlf_pkg::*;
#(
  parameter int BUF_BITS = 80,
  parameter int PWD_W    = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int LEN_W    = 7
) (
  input  cmd_flags_t          fl,
  input  logic [PWD_W-1:0]    pwd,
  input  logic [DATA_W-1:0]   data,
  input  logic [ADDR_W-1:0]   addr,
  output logic [BUF_BITS-1:0] frame,
  output logic [LEN_W-1:0]    len,
  output logic                too_long
);

  // Bit 0 of the frame leaves first, so each field is reversed before it is placed.
  logic [PWD_W-1:0]  pwd_rev;
  logic [DATA_W-1:0] data_rev;
  logic [ADDR_W-1:0] addr_rev;
  int                pos;

  assign pwd_rev  = {<<{pwd}};
  assign data_rev = {<<{data}};
  assign addr_rev = {<<{addr}};

  always_comb begin
    frame = '0;
    pos   = ref_zeros(fl.mode);
    if (fl.reset) begin
      pos = pos + 2;
    end else begin
      if (!fl.test) frame = frame | (BUF_BITS'(1'b1) << pos);
      pos = pos + 1;
      if (fl.test || fl.page) frame = frame | (BUF_BITS'(1'b1) << pos);
      pos = pos + 1;
      if (fl.pwd_en) begin
        if (pads_password(fl.mode)) pos = pos + 2;
        frame = frame | (BUF_BITS'(pwd_rev) << pos);
        pos   = pos + PWD_W;
      end
      if (!fl.reg_rd) pos = pos + 1;
      if (!fl.rd_only) begin
        frame = frame | (BUF_BITS'(data_rev) << pos);
        pos   = pos + DATA_W;
      end
      if (!fl.reg_rd) begin
        frame = frame | (BUF_BITS'(addr_rev) << pos);
        pos   = pos + ADDR_W;
      end
    end
    len      = LEN_W'(pos);
    too_long = pos > BUF_BITS;
  end

endmodule

// File: rtl/dlf_shifter.sv
module dlf_shifter #(
  parameter int BUF_BITS = 80,
  parameter int LEN_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [BUF_BITS-1:0] frame_in,
  input  logic [LEN_W-1:0]    len_in,
  input  logic                ready,
  output logic                valid,
  output logic                data,
  output logic                last,
  output logic                busy
);

  logic [BUF_BITS-1:0] sreg;
  logic [LEN_W-1:0]    left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sreg <= frame_in;
      left <= len_in;
      busy <= 1'b1;
    end else if (busy && ready) begin
      sreg <= sreg >> 1;
      left <= left - LEN_W'(1);
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end

  assign valid = busy;
  assign data  = sreg[0];
  assign last  = busy && (left == LEN_W'(1));

endmodule

// File: rtl/dl_frame_asm.sv
module dl_frame_asm
  import dlf_pkg::*;
#(
  parameter int BUF_BITS = 80,
  parameter int PWD_W    = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  localparam int MAX_FRAME = 6 + PWD_W + 1 + DATA_W + ADDR_W,
  localparam int LEN_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cmd_flags,
  input  logic [PWD_W-1:0]  password,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic              busy,
  output logic [LEN_W-1:0]  frame_len,
  output logic [1:0]        dl_mode,
  output logic              reject,
  output logic              bit_valid,
  input  logic              bit_ready,
  output logic              bit_data,
  output logic              bit_last
);

  cmd_flags_t          fl;
  logic [BUF_BITS-1:0] frame;
  logic [LEN_W-1:0]    len;
  logic                too_long;
  logic                accept;

  assign fl     = cmd_flags_t'(cmd_flags);
  assign accept = start && !busy;

  dlf_builder #(
    .BUF_BITS(BUF_BITS), .PWD_W(PWD_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_build (
    .fl(fl), .pwd(password), .data(wr_data), .addr(blk_addr),
    .frame(frame), .len(len), .too_long(too_long)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_len <= '0;
      dl_mode   <= 2'b00;
      reject    <= 1'b0;
    end else begin
      reject <= accept && too_long;
      if (accept) begin
        frame_len <= len;
        if (!too_long) dl_mode <= fl.mode;
      end
    end
  end

  dlf_shifter #(.BUF_BITS(BUF_BITS), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !too_long), .frame_in(frame), .len_in(len),
    .ready(bit_ready), .valid(bit_valid), .data(bit_data),
    .last(bit_last), .busy(busy)
  );

endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [LEN_W-1:0] frame_len,
  input logic [1:0]       dl_mode,
  input logic             reject,
  input logic             bit_valid,
  input logic             bit_ready,
  input logic             bit_data,
  input logic             bit_last
);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_last)); // R9

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bit_last |-> bit_valid); // R9

  AST_BUSY_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_valid && bit_ready && bit_last)); // R10

  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy && !bit_valid); // R11

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(frame_len))); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(dl_mode))); // R12

endmodule

bind dl_frame_asm dlf_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .frame_len(frame_len),
  .dl_mode(dl_mode), .reject(reject), .bit_valid(bit_valid),
  .bit_ready(bit_ready), .bit_data(bit_data), .bit_last(bit_last)
);

// File: tb/dl_frame_asm_tb.sv
module dl_frame_asm_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd_flags = '0;
  logic [31:0] password = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  blk_addr = '0;
  logic        bit_ready = 1'b0;
  logic        busy, reject, bit_valid, bit_data, bit_last;
  logic [LEN_W-1:0] frame_len;
  logic [1:0]  dl_mode;

  logic        s_start = 1'b0;
  logic [7:0]  s_flags = '0;
  logic        s_busy, s_reject, s_valid, s_data, s_last;
  logic [LEN_W-1:0] s_len;
  logic [1:0]  s_mode;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dl_frame_asm u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_flags(cmd_flags),
    .password(password), .wr_data(wr_data), .blk_addr(blk_addr),
    .busy(busy), .frame_len(frame_len), .dl_mode(dl_mode), .reject(reject),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .bit_last(bit_last)
  );

  dl_frame_asm #(.BUF_BITS(40)) u_small (
    .clk(clk), .rst_n(rst_n), .start(s_start), .cmd_flags(s_flags),
    .password(32'hDEAD_BEEF), .wr_data(32'h1234_5678), .blk_addr(3'd6),
    .busy(s_busy), .frame_len(s_len), .dl_mode(s_mode), .reject(s_reject),
    .bit_valid(s_valid), .bit_ready(1'b1), .bit_data(s_data),
    .bit_last(s_last)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_field(logic [31:0] v, int n);
    for (int k = n - 1; k >= 0; k--) exp_q.push_back(v[k]);
  endtask

  task automatic build_exp(logic [7:0] f, logic [31:0] pw, logic [31:0] dt, logic [2:0] ad);
    int mode = int'(f[4:3]);
    exp_q.delete();
    if (mode >= 2) exp_q.push_back(1'b0);
    if (mode == 3) exp_q.push_back(1'b0);
    if (f[7]) begin
      push_field(32'd0, 2);
    end else begin
      if (f[2]) push_field(32'd1, 2);
      else      push_field({30'd0, 1'b1, f[1]}, 2);
      if (f[0]) begin
        if (mode >= 2) push_field(32'd0, 2);
        push_field(pw, 32);
      end
      if (!f[5]) exp_q.push_back(1'b0);
      if (!f[6]) push_field(dt, 32);
      if (!f[5]) push_field({29'd0, ad}, 3);
    end
  endtask

  task automatic run_cmd(string tag, logic [7:0] f, logic [31:0] pw, logic [31:0] dt,
                         logic [2:0] ad, int stall, bit disturb);
    int idx = 0;
    int cyc = 0;
    int guard = 0;
    bit prev_stall = 0;
    logic held_d = 1'b0;
    logic held_l = 1'b0;
    bit rdy;
    build_exp(f, pw, dt, ad);
    @(negedge clk);
    cmd_flags = f; password = pw; wr_data = dt; blk_addr = ad; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", {tag, " busy after start"}, int'(busy), 1);
    check(int'(frame_len) == exp_q.size(), "R8", {tag, " frame_len"}, int'(frame_len), exp_q.size());
    check(dl_mode == f[4:3], "R12", {tag, " dl_mode"}, int'(dl_mode), int'(f[4:3]));
    while (idx < exp_q.size() && guard < 2000) begin
      guard++;
      if (!bit_valid) check(0, "R9", {tag, " valid dropped"}, 0, 1);
      if (prev_stall)
        check(bit_data == held_d && bit_last == held_l, "R9", {tag, " stall hold"},
              int'({bit_data, bit_last}), int'({held_d, held_l}));
      if (disturb && idx == 5 && !prev_stall) begin
        start = 1'b1; cmd_flags = ~f; password = ~pw; wr_data = ~dt; blk_addr = ~ad;
      end
      rdy = (stall == 0) || (cyc % stall != 0);
      bit_ready = rdy;
      if (rdy) begin
        check(bit_data == exp_q[idx], tag, $sformatf("bit %0d", idx), int'(bit_data), int'(exp_q[idx]));
        check(bit_last == (idx == exp_q.size() - 1), "R9", $sformatf("%s last at %0d", tag, idx),
              int'(bit_last), int'(idx == exp_q.size() - 1));
        idx++;
      end else begin
        held_d = bit_data; held_l = bit_last;
      end
      prev_stall = !rdy;
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    bit_ready = 1'b0;
    check(!busy && !bit_valid, "R10", {tag, " idle after last"}, int'({busy, bit_valid}), 0);
    if (disturb)
      check(int'(frame_len) == exp_q.size(), "R10", {tag, " length kept"}, int'(frame_len), exp_q.size());
  endtask

  task automatic t_reset();
    check(!busy && !bit_valid && !bit_last && !reject && frame_len == '0, "R1", "reset state",
          int'({busy, bit_valid, bit_last, reject}) + int'(frame_len), 0);
  endtask

  task automatic t_reset_cmds();
    for (int m = 0; m < 4; m++) begin
      run_cmd("R4", {1'b1, 2'b00, 2'(m), 3'b011}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, 0, 0);
      check(int'(frame_len) == 2 + (m >= 2 ? m - 1 : 0), "R3", "reset length", int'(frame_len),
            2 + (m >= 2 ? m - 1 : 0));
    end
  endtask

  task automatic t_overflow();
    @(negedge clk);
    s_flags = 8'h19; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    check(s_reject == 1'b1, "R11", "reject pulse", int'(s_reject), 1);
    check(!s_busy && !s_valid, "R11", "no frame started", int'({s_busy, s_valid}), 0);
    check(int'(s_len) == 74, "R8", "rejected length", int'(s_len), 74);
    @(negedge clk);
    check(!s_reject && !s_valid, "R11", "reject one cycle", int'({s_reject, s_valid}), 0);
    s_flags = 8'h98; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    check(s_busy && int'(s_len) == 4 && s_mode == 2'd3, "R11", "short frame accepted",
          int'(s_len), 4);
    repeat (4) @(negedge clk);
    check(!s_busy, "R11", "short frame done", int'(s_busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd("R2", 8'h02, 32'h0, 32'hA5C3_0F81, 3'd5, 3, 0);
    run_cmd("R2", 8'h08, 32'h0, 32'h8000_0001, 3'd1, 0, 0);
    t_reset_cmds();
    run_cmd("R5", 8'h0C, 32'h0, 32'h5555_AAAA, 3'd2, 2, 0);
    run_cmd("R6", 8'h11, 32'hC001_D00D, 32'h0F0F_F0F0, 3'd3, 0, 0);
    run_cmd("R6", 8'h1B, 32'h8765_4321, 32'hFEDC_BA98, 3'd7, 4, 0);
    check(int'(frame_len) == 74, "R6", "mode 3 password write length", int'(frame_len), 74);
    run_cmd("R7", 8'h41, 32'h1357_9BDF, 32'hFFFF_FFFF, 3'd4, 0, 0);
    run_cmd("R7", 8'h79, 32'h2468_ACE0, 32'hFFFF_FFFF, 3'd7, 2, 0);
    run_cmd("R10", 8'h0A, 32'h0, 32'h3C3C_C3C3, 3'd6, 2, 1);
    t_overflow();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule